// File: doc/BRIEF.md
# Watchdog Timer With Early Warning

This block is a supervisory timer that software must service at regular intervals. It advances once per tick of a slow time base, qualified by `tick_en`. If software does not service it before the count reaches its terminal value, the block raises a reset request for a fixed number of clock cycles. It also latches a sticky status bit so that boot code can tell a watchdog restart from a power-loss restart. The count then begins again from zero.

A configurable number of ticks before the terminal count, the block raises a warning flag. Firmware can use that flag to save state or to service the timer at the last moment. Software reaches the block through a byte-wide write port with a one-bit register select:

- Register 0 (service): only a write of 0xFF services the timer. Any other value is ignored.
- Register 1 (flags): bit 0 is the warning flag and bit 1 is the overflow status. Writing 0 to a bit clears it, and writing 1 to a bit leaves it unchanged.

The warning flag also clears on a falling edge of the `wake` input. The overflow status is held clear for as long as `ext_reset` is high.

Top module: `wdt_early_warn`

## Requirements
- R1: A write of 0xFF to register 0 (wr_addr = 0) sets the count to zero. When a tick arrives in the same cycle, the write takes priority. The next overflow then comes TIMEOUT_TICKS ticks after that write.
- R2: A write of any value other than 0xFF to register 0, and any write to register 1, leaves the count unchanged. Such writes do not delay the overflow.
- R3: On the TIMEOUT_TICKS-th tick after the count was last zeroed, rst_req goes high in the following cycle and stays high for exactly RST_PULSE_CYCLES clock cycles. The count restarts from zero, so the next overflow follows TIMEOUT_TICKS ticks later.
- R4: warn_flag becomes 1 after the tick that leaves WARN_LEAD_TICKS ticks before overflow, that is, tick number TIMEOUT_TICKS − WARN_LEAD_TICKS counted since the last zeroing. It is still 0 after the tick before that one.
- R5: A write to register 1 with bit 0 = 0 clears warn_flag. A write with bit 0 = 1 leaves warn_flag unchanged.
- R6: A falling edge on wake (high in one cycle, low in the next) clears warn_flag. A rising edge of wake has no effect.
- R7: ovf_status becomes 1 on overflow and then holds its value through service writes and later counting until it is explicitly cleared.
- R8: ovf_status is 0 in the cycle after any cycle with ext_reset high, including when an overflow occurs while ext_reset is high. A write to register 1 with bit 1 = 0 also clears it, and a write with bit 1 = 1 leaves it unchanged.
- R9: While rst_n is low and just after it is released, rst_req, warn_flag and ovf_status are all 0.
- R10: If an overflow coincides with a software write that would clear the flags, the newly set status wins and ovf_status reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe per slow-clock tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 service, 1 flags |
| wr_data | input | 8 | Write data byte |
| wake | input | 1 | Wake level; a falling edge clears the warning flag |
| ext_reset | input | 1 | External reset level; clears the overflow status while high |
| rst_req | output | 1 | Reset request pulse after overflow |
| warn_flag | output | 1 | Early-warning flag |
| ovf_status | output | 1 | Sticky overflow status |

## Verification
A count that is corrupted or zeroed at the wrong time shows at the ports as a warning flag or reset pulse that arrives on the wrong tick. Because every test reaches an overflow within a single timeout window of a known service write, the error is visible within TIMEOUT_TICKS ticks. The bench therefore samples rst_req and warn_flag on the exact tick before and the exact tick of each expected event. A flag register that loses or invents a set or a clear is visible on the very next cycle, because both flags are outputs. The bench checks them right after each write, wake edge and ext_reset change.

// File: rtl/wdt_ew_pkg.sv
package wdt_ew_pkg;

  // register select values
  typedef enum logic {
    REG_SERVICE = 1'b0,
    REG_FLAGS   = 1'b1
  } wdt_reg_e;

  localparam logic [7:0] SERVICE_CODE = 8'hFF;
  localparam int unsigned FLAG_WARN_BIT = 0;
  localparam int unsigned FLAG_OVF_BIT  = 1;

  // count value on which the next tick is the overflow
  function automatic logic wdt_is_terminal(input int unsigned cnt,
                                           input int unsigned timeout);
    return cnt == timeout - 1;
  endfunction

  // count value on which the next tick leaves 'lead' ticks to overflow
  function automatic logic wdt_is_warn_point(input int unsigned cnt,
                                             input int unsigned timeout,
                                             input int unsigned lead);
    return cnt == timeout - 1 - lead;
  endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_ew_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS   = 49152,
  parameter int unsigned WARN_LEAD_TICKS = 33,
  parameter int unsigned CW              = $clog2(TIMEOUT_TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          service,
  output logic [CW-1:0] cnt,
  output logic          warn_hit,
  output logic          ovf_hit
);

  logic live_tick;
  assign live_tick = tick_en && !service;
  assign warn_hit  = live_tick && wdt_is_warn_point(32'(cnt), TIMEOUT_TICKS, WARN_LEAD_TICKS);
  assign ovf_hit   = live_tick && wdt_is_terminal(32'(cnt), TIMEOUT_TICKS);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (service)    cnt <= '0;
    else if (ovf_hit)    cnt <= '0;
    else if (live_tick)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_hit,
  input  logic ovf_hit,
  input  logic warn_sw_clr,
  input  logic ovf_sw_clr,
  input  logic wake_fall,
  input  logic ext_reset,
  output logic warn_flag,
  output logic ovf_status
);

  always_ff @(posedge clk) begin
    if (!rst_n)                        warn_flag <= 1'b0;
    else if (warn_hit)                 warn_flag <= 1'b1;
    else if (warn_sw_clr || wake_fall) warn_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ovf_status <= 1'b0;
    else if (ext_reset)  ovf_status <= 1'b0;
    else if (ovf_hit)    ovf_status <= 1'b1;
    else if (ovf_sw_clr) ovf_status <= 1'b0;
  end

endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned RST_PULSE_CYCLES = 8,
  parameter int unsigned PW               = $clog2(RST_PULSE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)         left <= '0;
    else if (trig)      left <= PW'(RST_PULSE_CYCLES);
    else if (left != 0) left <= left - 1'b1;
  end

  assign pulse = (left != 0);

endmodule

// File: rtl/wdt_early_warn.sv
module wdt_early_warn
  import wdt_ew_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS    = 49152,
  parameter int unsigned WARN_LEAD_TICKS  = 33,
  parameter int unsigned RST_PULSE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       wake,
  input  logic       ext_reset,
  output logic       rst_req,
  output logic       warn_flag,
  output logic       ovf_status
);

  localparam int unsigned CW = $clog2(TIMEOUT_TICKS);

  logic          service, flags_wr, warn_sw_clr, ovf_sw_clr;
  logic          wake_q, wake_fall;
  logic          warn_hit, ovf_hit;
  logic [CW-1:0] cnt;

  assign service     = wr_en && (wr_addr == REG_SERVICE) && (wr_data == SERVICE_CODE);
  assign flags_wr    = wr_en && (wr_addr == REG_FLAGS);
  assign warn_sw_clr = flags_wr && !wr_data[FLAG_WARN_BIT];
  assign ovf_sw_clr  = flags_wr && !wr_data[FLAG_OVF_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake;
  end
  assign wake_fall = wake_q && !wake;

  wdt_counter #(
    .TIMEOUT_TICKS  (TIMEOUT_TICKS),
    .WARN_LEAD_TICKS(WARN_LEAD_TICKS),
    .CW             (CW)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .service (service),
    .cnt     (cnt),
    .warn_hit(warn_hit),
    .ovf_hit (ovf_hit)
  );

  wdt_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .warn_hit   (warn_hit),
    .ovf_hit    (ovf_hit),
    .warn_sw_clr(warn_sw_clr),
    .ovf_sw_clr (ovf_sw_clr),
    .wake_fall  (wake_fall),
    .ext_reset  (ext_reset),
    .warn_flag  (warn_flag),
    .ovf_status (ovf_status)
  );

  wdt_pulse #(
    .RST_PULSE_CYCLES(RST_PULSE_CYCLES)
  ) u_pulse (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (ovf_hit),
    .pulse(rst_req)
  );

endmodule

// File: rtl/wdt_early_warn_chk.sv
module wdt_early_warn_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_en,
  input logic          wr_addr,
  input logic [7:0]    wr_data,
  input logic          wake,
  input logic          ext_reset,
  input logic          rst_req,
  input logic          warn_flag,
  input logic          ovf_status,
  input logic [CW-1:0] cnt,
  input logic          warn_hit,
  input logic          ovf_hit
);

  a_r1_service_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && wr_data == 8'hFF) |=> (cnt == '0));

  a_r2_other_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(wr_addr == 1'b0 && wr_data == 8'hFF) && !tick_en) |=> (cnt == $past(cnt)));

  a_r3_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (rst_req && cnt == '0));

  a_r4_warn_sets: assert property (@(posedge clk) disable iff (!rst_n)
    warn_hit |=> warn_flag);

  a_r5_sw_warn_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr && !wr_data[0] && !warn_hit) |=> !warn_flag);

  a_r6_wake_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $fell(wake) && !warn_hit) |=> !warn_flag);

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_hit && !ext_reset && !(wr_en && wr_addr && !wr_data[1])) |=> $stable(ovf_status));

  a_r8_ext_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ext_reset |=> !ovf_status);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_hit && !ext_reset) |=> ovf_status);

endmodule

bind wdt_early_warn wdt_early_warn_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wake      (wake),
  .ext_reset (ext_reset),
  .rst_req   (rst_req),
  .warn_flag (warn_flag),
  .ovf_status(ovf_status),
  .cnt       (cnt),
  .warn_hit  (warn_hit),
  .ovf_hit   (ovf_hit)
);

// File: tb/tb_wdt_early_warn.sv
`timescale 1ns/1ps
module tb_wdt_early_warn;

  localparam int unsigned T    = 64;
  localparam int unsigned LEAD = 8;
  localparam int unsigned PULS = 3;
  localparam int unsigned WARN_TICK = T - LEAD;   // 56

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wake = 1'b0;
  logic       ext_reset = 1'b0;
  logic       rst_req, warn_flag, ovf_status;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  wdt_early_warn #(
    .TIMEOUT_TICKS   (T),
    .WARN_LEAD_TICKS (LEAD),
    .RST_PULSE_CYCLES(PULS)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wake      (wake),
    .ext_reset (ext_reset),
    .rst_req   (rst_req),
    .warn_flag (warn_flag),
    .ovf_status(ovf_status)
  );

  // {addr, data, refresh expected}
  localparam logic [9:0] VEC [0:6] = '{
    {1'b0, 8'hFF, 1'b1},
    {1'b0, 8'h00, 1'b0},
    {1'b0, 8'hFE, 1'b0},
    {1'b0, 8'h7F, 1'b0},
    {1'b0, 8'hF0, 1'b0},
    {1'b1, 8'hFF, 1'b0},
    {1'b0, 8'hFF, 1'b1}
  };

  task automatic check(input string req, input string what, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step(1);
    wr_en = 1'b0; wr_data = 8'h00; wr_addr = 1'b0;
  endtask

  // clear both flags, then service; count is zero after the service edge
  task automatic restart();
    write_reg(1'b1, 8'h00);
    write_reg(1'b0, 8'hFF);
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    check("R9", "rst_req in reset", rst_req, 1'b0);
    check("R9", "warn in reset", warn_flag, 1'b0);
    check("R9", "ovf in reset", ovf_status, 1'b0);
    rst_n = 1'b1;
    tick_en = 1'b1;
    step(1);
    check("R9", "ovf after release", ovf_status, 1'b0);
    check("R9", "rst_req after release", rst_req, 1'b0);

    // R4 / R3 timing
    restart();
    step(WARN_TICK - 1);
    check("R4", "warn one tick early", warn_flag, 1'b0);
    step(1);
    check("R4", "warn at lead", warn_flag, 1'b1);
    step(T - WARN_TICK - 1);
    check("R3", "rst_req before overflow", rst_req, 1'b0);
    step(1);
    check("R3", "rst_req at overflow", rst_req, 1'b1);
    check("R7", "ovf set", ovf_status, 1'b1);
    step(PULS - 1);
    check("R3", "rst_req last pulse cycle", rst_req, 1'b1);
    step(1);
    check("R3", "rst_req pulse ended", rst_req, 1'b0);
    write_reg(1'b1, 8'h00);           // edge 68
    step(T - 1 - (PULS + 1) - 1 + 1); // to edge 127
    check("R3", "no early second overflow", ovf_status, 1'b0);
    step(1);
    check("R3", "count restarted at zero", ovf_status, 1'b1);

    // R7 sticky, R5 and R8 software clears
    write_reg(1'b0, 8'hFF);
    step(10);
    check("R7", "ovf sticky after service", ovf_status, 1'b1);
    write_reg(1'b1, 8'h03);
    check("R5", "write 1 keeps warn", warn_flag, 1'b1);
    check("R8", "write 1 keeps ovf", ovf_status, 1'b1);
    write_reg(1'b1, 8'h02);
    check("R5", "write 0 clears warn", warn_flag, 1'b0);
    check("R8", "ovf kept by bit1=1", ovf_status, 1'b1);
    write_reg(1'b1, 8'h01);
    check("R8", "write 0 clears ovf", ovf_status, 1'b0);

    // R6 wake edges
    restart();
    step(WARN_TICK);
    check("R6", "warn set before wake", warn_flag, 1'b1);
    write_reg(1'b0, 8'hFF);
    wake = 1'b1;
    step(1);
    check("R6", "rising wake no effect", warn_flag, 1'b1);
    step(1);
    check("R6", "high wake no effect", warn_flag, 1'b1);
    wake = 1'b0;
    step(1);
    check("R6", "falling wake clears", warn_flag, 1'b0);

    // R8 external reset
    restart();
    step(T);
    check("R8", "ovf set before ext", ovf_status, 1'b1);
    ext_reset = 1'b1;
    step(1);
    check("R8", "ext clears ovf", ovf_status, 1'b0);
    step(T);
    check("R8", "overflow under ext not latched", ovf_status, 1'b0);
    ext_reset = 1'b0;
    step(1);
    check("R8", "ovf after ext low", ovf_status, 1'b0);

    // R10 coincident set and clear
    restart();
    step(T - 1);
    write_reg(1'b1, 8'h00);
    check("R10", "overflow beats clear", ovf_status, 1'b1);
    check("R10", "warn cleared by write", warn_flag, 1'b0);

    // R1 / R2 table of writes to service register
    for (int v = 0; v < 7; v++) begin
      step(PULS + 1);
      restart();
      step(39);
      write_reg(VEC[v][9], VEC[v][8:1]);  // edge 40
      step(T - 40);                        // edge 64
      check(VEC[v][0] ? "R1" : "R2", "ovf at old deadline", ovf_status, !VEC[v][0]);
      check(VEC[v][0] ? "R1" : "R2", "rst_req at old deadline", rst_req, !VEC[v][0]);
      check(VEC[v][0] ? "R1" : "R2", "warn by old deadline", warn_flag, !VEC[v][0]);
    end

    // R1 exact new deadline after service at edge 40
    step(PULS + 1);
    restart();
    step(39);
    write_reg(1'b0, 8'hFF);
    step(T - 1);
    check("R1", "no overflow one tick before new deadline", ovf_status, 1'b0);
    step(1);
    check("R1", "overflow at new deadline", ovf_status, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule